// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block tracks the coherence state of a small array of cache lines belonging to one cache on a shared bus. Lines are updated in place rather than invalidated when another cache writes. A line can be owned while shared, so main memory is written only when the owning copy is evicted. The controller accepts local processor requests (read, write, evict) through a valid/ready handshake. It watches snooped bus events (a remote read miss or a remote update broadcast). It also samples the wired shared line that the other caches drive.

For every accepted local request the controller returns, one cycle later, whether the access hit, the line's new state, and the bus actions it needs: a fetch of the line, a broadcast of the updated block, and a write-back of the old contents. For every snooped event it raises its own snoop-hit output in the same cycle, which feeds the shared line of the other caches. One cycle later it requests either a supply of the line to the requester or an update of the local copy. Data storage, bus arbitration and memory timing are left to the surrounding logic.

Line states are encoded on `resp_state_o` as invalid=0, valid exclusive=1, shared clean=2, shared dirty=3, dirty=4. Local operation codes on `req_op_i` are read=0, write=1, evict=2. Snoop codes on `snoop_op_i` are remote read=0, remote update=1. A line is indexed by `req_idx_i` / `snoop_idx_i`. It hits when it is not invalid and its stored tag equals the presented tag.

Top module: `coh_upd_ctrl`

## Requirements
- R1: After reset every line is invalid (state 0): the first access to any line misses, and no snoop hits it.
- R2: A read (op 0) that hits returns resp_hit_o=1 with the state unchanged and no fetch, update broadcast or write-back.
- R3: A read that misses asserts bus_fetch_o and enters valid exclusive (1) when shared_i was low in the accept cycle, or shared clean (2) when it was high; the new tag is stored.
- R4: A write (op 1) that hits a line in valid exclusive (1) or dirty (4) enters dirty with no bus traffic.
- R5: A write that hits a line in shared clean (2) or shared dirty (3) enters shared dirty and asserts bus_upd_o.
- R6: A write that misses asserts bus_fetch_o; with shared_i high it enters shared dirty (3) and asserts bus_upd_o, with shared_i low it enters dirty (4) without a broadcast.
- R7: An evict (op 2) makes the indexed line invalid and asserts wb_o only when the line was dirty (4) or shared dirty (3).
- R8: A snooped remote read (snoop op 0) that hits a line raises snoop_hit_o in the same cycle and supply_o one cycle later; the line goes from valid exclusive or shared clean to shared clean, and from dirty or shared dirty to shared dirty.
- R9: A snooped update broadcast (snoop op 1) that hits a line raises snoop_hit_o in the same cycle and copy_upd_o one cycle later, and the line enters shared clean.
- R10: A snoop with a tag mismatch or on an invalid line raises neither snoop_hit_o, supply_o nor copy_upd_o and leaves the line's state and tag unchanged.
- R11: While bus_busy_i or snoop_valid_i is high, req_ready_o is low and no request is accepted; each accepted request yields exactly one resp_valid_o pulse one cycle later.
- R12: A read or write miss that replaces a valid line of another tag in dirty or shared dirty state also asserts wb_o; replacing an invalid, valid exclusive or shared clean line does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Local request valid |
| req_ready_o | output | 1 | Local request accepted when high with valid |
| req_op_i | input | 2 | Local operation: 0 read, 1 write, 2 evict |
| req_idx_i | input | IDX_W | Line index of the request |
| req_tag_i | input | TAG_W | Tag of the request |
| shared_i | input | 1 | Wired-OR shared line from the other caches, sampled at accept |
| bus_busy_i | input | 1 | Bus is granted to another cache |
| resp_valid_o | output | 1 | Result of an accepted request |
| resp_hit_o | output | 1 | The request hit |
| resp_state_o | output | 3 | New state of the addressed line |
| bus_fetch_o | output | 1 | Fetch the line over the bus |
| bus_upd_o | output | 1 | Broadcast the updated block |
| wb_o | output | 1 | Write the old line back to memory |
| snoop_valid_i | input | 1 | Snooped bus event present |
| snoop_op_i | input | 1 | Snoop kind: 0 remote read, 1 update broadcast |
| snoop_idx_i | input | IDX_W | Line index of the snooped address |
| snoop_tag_i | input | TAG_W | Tag of the snooped address |
| snoop_hit_o | output | 1 | This cache holds the snooped line (to the shared line) |
| supply_o | output | 1 | Supply the line to the remote requester |
| copy_upd_o | output | 1 | Update the local copy from the broadcast |

## Verification
Each line is driven through every state by reads and writes under both levels of the shared line. This separates the exclusive fill from the shared fill, and the silent write from the broadcasting write. Snoops arrive on lines held clean and dirty, so a supply that keeps ownership can be told from one that drops to shared clean. Evictions and conflicting-tag misses on dirty, owned-shared and clean lines show when a write-back is owed. Snoops with stale tags and on evicted lines, followed by a read hit, show that a miss disturbs nothing. A held request under a busy bus shows the stall.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;
  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_VE = 3'd1,
    ST_SC = 3'd2,
    ST_SD = 3'd3,
    ST_D  = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD = 2'd0,
    OP_WR = 2'd1,
    OP_EV = 2'd2,
    OP_NP = 2'd3
  } lop_e;

  localparam logic SN_RD  = 1'b0;
  localparam logic SN_UPD = 1'b1;

  typedef struct packed {
    line_st_e st;
    logic     fetch;
    logic     upd;
    logic     wb;
    logic     tag_ld;
  } local_act_t;

  function automatic logic is_owner(line_st_e s);
    return (s == ST_D) || (s == ST_SD);
  endfunction
endpackage

// File: rtl/coh_line_array.sv
`timescale 1ns/1ps
module coh_line_array
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  line_st_e                        wr_st_i,
  input  logic                            wr_tag_en_i,
  input  logic [TAG_W-1:0]                wr_tag_i,
  output line_st_e [NUM_LINES-1:0]        st_o,
  output logic [NUM_LINES-1:0][TAG_W-1:0] tag_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    line_st_e         st_q;
    logic [TAG_W-1:0] tag_q;
    logic             sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= ST_I;
        tag_q <= '0;
      end else if (sel) begin
        st_q <= wr_st_i;
        if (wr_tag_en_i) tag_q <= wr_tag_i;
      end
    end

    assign st_o[g]  = st_q;
    assign tag_o[g] = tag_q;
  end
endmodule

// File: rtl/coh_local_fsm.sv
`timescale 1ns/1ps
module coh_local_fsm
  import coh_pkg::*;
(
  input  line_st_e   cur_st_i,
  input  logic       hit_i,
  input  logic [1:0] op_i,
  input  logic       shared_i,
  output local_act_t act_o
);
  always_comb begin
    act_o        = '0;
    act_o.st     = cur_st_i;
    unique case (lop_e'(op_i))
      OP_RD: begin
        if (!hit_i) begin
          act_o.fetch  = 1'b1;
          act_o.tag_ld = 1'b1;
          act_o.wb     = is_owner(cur_st_i);  // victim owed to memory
          act_o.st     = shared_i ? ST_SC : ST_VE;
        end
      end
      OP_WR: begin
        if (hit_i) begin
          if (cur_st_i == ST_VE || cur_st_i == ST_D) begin
            act_o.st = ST_D;
          end else begin
            act_o.st  = ST_SD;
            act_o.upd = 1'b1;
          end
        end else begin
          act_o.fetch  = 1'b1;
          act_o.tag_ld = 1'b1;
          act_o.wb     = is_owner(cur_st_i);
          act_o.st     = shared_i ? ST_SD : ST_D;
          act_o.upd    = shared_i;
        end
      end
      OP_EV: begin
        act_o.wb = is_owner(cur_st_i);
        act_o.st = ST_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_snoop_fsm.sv
`timescale 1ns/1ps
module coh_snoop_fsm
  import coh_pkg::*;
(
  input  line_st_e cur_st_i,
  input  logic     hit_i,
  input  logic     op_i,
  output line_st_e nxt_st_o,
  output logic     supply_o,
  output logic     copy_upd_o
);
  always_comb begin
    nxt_st_o   = cur_st_i;
    supply_o   = 1'b0;
    copy_upd_o = 1'b0;
    if (hit_i) begin
      if (op_i == SN_RD) begin
        supply_o = 1'b1;
        nxt_st_o = is_owner(cur_st_i) ? ST_SD : ST_SC;  // owner keeps ownership
      end else begin
        copy_upd_o = 1'b1;
        nxt_st_o   = ST_SC;
      end
    end
  end
endmodule

// File: rtl/coh_upd_ctrl.sv
`timescale 1ns/1ps
module coh_upd_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [IDX_W-1:0] req_idx_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             shared_i,
  input  logic             bus_busy_i,
  output logic             resp_valid_o,
  output logic             resp_hit_o,
  output logic [2:0]       resp_state_o,
  output logic             bus_fetch_o,
  output logic             bus_upd_o,
  output logic             wb_o,
  input  logic             snoop_valid_i,
  input  logic             snoop_op_i,
  input  logic [IDX_W-1:0] snoop_idx_i,
  input  logic [TAG_W-1:0] snoop_tag_i,
  output logic             snoop_hit_o,
  output logic             supply_o,
  output logic             copy_upd_o
);
  line_st_e [NUM_LINES-1:0]        st_arr;
  logic [NUM_LINES-1:0][TAG_W-1:0] tag_arr;

  line_st_e   cur_l, cur_s, s_nxt;
  logic       hit_l, hit_s, fire;
  logic       s_supply, s_cupd;
  local_act_t l_act;

  logic             wr_en, wr_tag_en;
  logic [IDX_W-1:0] wr_idx;
  line_st_e         wr_st;

  // snoops take the array; local requests wait
  assign req_ready_o = !bus_busy_i && !snoop_valid_i;
  assign fire        = req_valid_i && req_ready_o;

  assign cur_l = st_arr[req_idx_i];
  assign hit_l = (cur_l != ST_I) && (tag_arr[req_idx_i] == req_tag_i);

  assign cur_s = st_arr[snoop_idx_i];
  assign hit_s = snoop_valid_i && (cur_s != ST_I) && (tag_arr[snoop_idx_i] == snoop_tag_i);
  assign snoop_hit_o = hit_s;

  coh_local_fsm i_local (
    .cur_st_i (cur_l),
    .hit_i    (hit_l),
    .op_i     (req_op_i),
    .shared_i (shared_i),
    .act_o    (l_act)
  );

  coh_snoop_fsm i_snoop (
    .cur_st_i   (cur_s),
    .hit_i      (hit_s),
    .op_i       (snoop_op_i),
    .nxt_st_o   (s_nxt),
    .supply_o   (s_supply),
    .copy_upd_o (s_cupd)
  );

  always_comb begin
    wr_en     = 1'b0;
    wr_idx    = req_idx_i;
    wr_st     = l_act.st;
    wr_tag_en = 1'b0;
    if (hit_s) begin
      wr_en  = 1'b1;
      wr_idx = snoop_idx_i;
      wr_st  = s_nxt;
    end else if (fire) begin
      wr_en     = 1'b1;
      wr_tag_en = l_act.tag_ld;
    end
  end

  coh_line_array #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W)
  ) i_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_st_i     (wr_st),
    .wr_tag_en_i (wr_tag_en),
    .wr_tag_i    (req_tag_i),
    .st_o        (st_arr),
    .tag_o       (tag_arr)
  );

  line_st_e resp_st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_st_q    <= ST_I;
      bus_fetch_o  <= 1'b0;
      bus_upd_o    <= 1'b0;
      wb_o         <= 1'b0;
      supply_o     <= 1'b0;
      copy_upd_o   <= 1'b0;
    end else begin
      resp_valid_o <= fire;
      resp_hit_o   <= fire && hit_l;
      bus_fetch_o  <= fire && l_act.fetch;
      bus_upd_o    <= fire && l_act.upd;
      wb_o         <= fire && l_act.wb;
      if (fire) resp_st_q <= l_act.st;
      supply_o     <= s_supply;
      copy_upd_o   <= s_cupd;
    end
  end

  assign resp_state_o = resp_st_q;
endmodule

// File: rtl/coh_upd_ctrl_chk.sv
`timescale 1ns/1ps
module coh_upd_ctrl_chk
  import coh_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [1:0] req_op_i,
  input logic       shared_i,
  input logic       bus_busy_i,
  input logic       resp_valid_o,
  input logic       resp_hit_o,
  input logic [2:0] resp_state_o,
  input logic       bus_fetch_o,
  input logic       bus_upd_o,
  input logic       wb_o,
  input logic       snoop_valid_i,
  input logic       snoop_op_i,
  input logic       snoop_hit_o,
  input logic       supply_o,
  input logic       copy_upd_o,
  input line_st_e   lin_st_i,
  input logic       lin_hit_i
);
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  p_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_busy_i || snoop_valid_i) |-> !req_ready_o);

  p_one_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o);

  p_no_stray_resp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !resp_valid_o);

  p_rd_hit_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 2'd0 && lin_hit_i) |=>
      (resp_hit_o && !bus_fetch_o && !bus_upd_o && !wb_o && resp_state_o == $past(lin_st_i)));

  p_rd_miss_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 2'd0 && !lin_hit_i) |=>
      (bus_fetch_o && resp_state_o == ($past(shared_i) ? 3'd2 : 3'd1)));

  p_wr_hit_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 2'd1 && lin_hit_i && (lin_st_i == ST_VE || lin_st_i == ST_D)) |=>
      (resp_state_o == 3'd4 && !bus_upd_o && !bus_fetch_o && !wb_o));

  p_wr_hit_shared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 2'd1 && lin_hit_i && (lin_st_i == ST_SC || lin_st_i == ST_SD)) |=>
      (resp_state_o == 3'd3 && bus_upd_o));

  p_wr_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 2'd1 && !lin_hit_i) |=>
      (bus_fetch_o && bus_upd_o == $past(shared_i) &&
       resp_state_o == ($past(shared_i) ? 3'd3 : 3'd4)));

  p_evict_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_op_i == 2'd2) |=>
      (resp_state_o == 3'd0 && wb_o == ($past(lin_st_i) == ST_D || $past(lin_st_i) == ST_SD)));

  p_supply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit_o && snoop_op_i == 1'b0) |=> (supply_o && !copy_upd_o));

  p_copy_upd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_hit_o && snoop_op_i == 1'b1) |=> (copy_upd_o && !supply_o));

  p_snoop_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snoop_hit_o |=> (!supply_o && !copy_upd_o));
endmodule

bind coh_upd_ctrl coh_upd_ctrl_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_op_i      (req_op_i),
  .shared_i      (shared_i),
  .bus_busy_i    (bus_busy_i),
  .resp_valid_o  (resp_valid_o),
  .resp_hit_o    (resp_hit_o),
  .resp_state_o  (resp_state_o),
  .bus_fetch_o   (bus_fetch_o),
  .bus_upd_o     (bus_upd_o),
  .wb_o          (wb_o),
  .snoop_valid_i (snoop_valid_i),
  .snoop_op_i    (snoop_op_i),
  .snoop_hit_o   (snoop_hit_o),
  .supply_o      (supply_o),
  .copy_upd_o    (copy_upd_o),
  .lin_st_i      (cur_l),
  .lin_hit_i     (hit_l)
);

// File: tb/test_coh_upd_ctrl.sv
`timescale 1ns/1ps
module test_coh_upd_ctrl;
  localparam int NL = 4;
  localparam int TW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_op = '0;
  logic [IW-1:0] req_idx = '0;
  logic [TW-1:0] req_tag = '0;
  logic          shared = 1'b0, bus_busy = 1'b0;
  logic          resp_valid, resp_hit, bus_fetch, bus_upd, wb;
  logic [2:0]    resp_state;
  logic          snoop_valid = 1'b0, snoop_op = 1'b0;
  logic [IW-1:0] snoop_idx = '0;
  logic [TW-1:0] snoop_tag = '0;
  logic          snoop_hit, supply, copy_upd;

  coh_upd_ctrl #(.NUM_LINES(NL), .TAG_W(TW)) i_coh_upd_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_idx_i(req_idx), .req_tag_i(req_tag), .shared_i(shared), .bus_busy_i(bus_busy),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_state_o(resp_state),
    .bus_fetch_o(bus_fetch), .bus_upd_o(bus_upd), .wb_o(wb),
    .snoop_valid_i(snoop_valid), .snoop_op_i(snoop_op), .snoop_idx_i(snoop_idx),
    .snoop_tag_i(snoop_tag), .snoop_hit_o(snoop_hit), .supply_o(supply), .copy_upd_o(copy_upd)
  );

  typedef struct {
    int         rq;
    logic       hit;
    logic [2:0] st;
    logic       f, u, w;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model of line states: 0 I, 1 VE, 2 SC, 3 SD, 4 D
  int         m_st[NL];
  logic [TW-1:0] m_tag[NL];

  task automatic chk(bit ok, int rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic bit owner(int s);
    return (s == 3) || (s == 4);
  endfunction

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q.size() == 0) begin
        chk(0, 11, "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(resp_hit === e.hit, e.rq, "hit", int'(resp_hit), int'(e.hit));
        chk(resp_state === e.st, e.rq, "state", int'(resp_state), int'(e.st));
        chk(bus_fetch === e.f, e.rq, "fetch", int'(bus_fetch), int'(e.f));
        chk(bus_upd === e.u, e.rq, "update", int'(bus_upd), int'(e.u));
        chk(wb === e.w, e.rq, "writeback", int'(wb), int'(e.w));
      end
    end
  end

  task automatic do_req(int rq, logic [1:0] op, int idx, logic [TW-1:0] tag, logic sh);
    exp_t e;
    bit   h;
    int   cur;
    cur = m_st[idx];
    h = (cur != 0) && (m_tag[idx] == tag);
    e.rq = rq; e.hit = h; e.f = 1'b0; e.u = 1'b0; e.w = 1'b0; e.st = 3'(cur);
    case (op)
      2'd0: if (!h) begin
        e.f = 1'b1; e.w = owner(cur); e.st = sh ? 3'd2 : 3'd1;
      end
      2'd1: if (h) begin
        if (cur == 1 || cur == 4) e.st = 3'd4;
        else begin e.st = 3'd3; e.u = 1'b1; end
      end else begin
        e.f = 1'b1; e.w = owner(cur);
        e.st = sh ? 3'd3 : 3'd4; e.u = sh;
      end
      default: begin e.w = owner(cur); e.st = 3'd0; end
    endcase
    if (op != 2'd2 && !h) m_tag[idx] = tag;
    m_st[idx] = int'(e.st);
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_idx = IW'(idx); req_tag = tag; shared = sh;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; shared = 1'b0;
  endtask

  task automatic do_snoop(int rq, logic op, int idx, logic [TW-1:0] tag);
    bit h;
    h = (m_st[idx] != 0) && (m_tag[idx] == tag);
    @(negedge clk);
    bus_busy = 1'b1; snoop_valid = 1'b1; snoop_op = op;
    snoop_idx = IW'(idx); snoop_tag = tag;
    #1;
    chk(snoop_hit === h, rq, "snoop_hit", int'(snoop_hit), int'(h));
    chk(req_ready === 1'b0, 11, "ready during snoop", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    snoop_valid = 1'b0; bus_busy = 1'b0;
    chk(supply === (h && op == 1'b0), rq, "supply", int'(supply), int'(h && op == 1'b0));
    chk(copy_upd === (h && op == 1'b1), rq, "copy_upd", int'(copy_upd), int'(h && op == 1'b1));
    if (h) m_st[idx] = (op == 1'b0) ? (owner(m_st[idx]) ? 3 : 2) : 2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(0, 11, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk(resp_valid === 1'b0, 1, "resp_valid after reset", int'(resp_valid), 0);
    chk(req_ready === 1'b1, 1, "ready after reset", int'(req_ready), 1);
    rst_n = 1'b1;
    do_snoop(1, 1'b0, 0, 8'h00);      // R1: no line valid, no hit
    do_req(1, 2'd0, 0, 8'h11, 1'b0);  // R1/R3: first read misses, fills exclusive
    do_req(2, 2'd0, 0, 8'h11, 1'b0);  // R2: read hit in VE
    do_req(4, 2'd1, 0, 8'h11, 1'b0);  // R4: VE -> D silently
    do_req(4, 2'd1, 0, 8'h11, 1'b1);  // R4: D stays D, shared ignored
    do_snoop(8, 1'b0, 0, 8'h11);      // R8: supply from D -> SD
    do_req(2, 2'd0, 0, 8'h11, 1'b0);  // R2: read hit in SD
    do_req(5, 2'd1, 0, 8'h11, 1'b0);  // R5: SD write broadcasts
    do_snoop(9, 1'b1, 0, 8'h11);      // R9: update -> SC
    do_req(5, 2'd1, 0, 8'h11, 1'b0);  // R5: SC write -> SD broadcast
    do_req(7, 2'd2, 0, 8'h11, 1'b0);  // R7: evict SD owes write-back
    do_req(3, 2'd0, 1, 8'h22, 1'b1);  // R3: shared fill -> SC
    do_snoop(8, 1'b0, 1, 8'h22);      // R8: supply from SC stays SC
    do_req(2, 2'd0, 1, 8'h22, 1'b0);  // R2: confirm SC via read hit
    do_req(7, 2'd2, 1, 8'h22, 1'b0);  // R7: evict SC, no write-back
    do_req(6, 2'd1, 2, 8'h33, 1'b1);  // R6: write miss shared -> SD + broadcast
    do_req(6, 2'd1, 3, 8'h44, 1'b0);  // R6: write miss alone -> D
    do_req(12, 2'd0, 3, 8'h55, 1'b0); // R12: read miss over D victim
    do_req(12, 2'd1, 2, 8'h66, 1'b0); // R12: write miss over SD victim
    do_req(12, 2'd1, 3, 8'h77, 1'b1); // R12: write miss over VE victim, no wb
    do_snoop(10, 1'b1, 2, 8'h33);     // R10: stale tag, no hit
    do_req(10, 2'd0, 2, 8'h66, 1'b0); // R10: line 2 still D after stale snoop
    do_snoop(10, 1'b0, 1, 8'h22);     // R10: invalid line ignores snoop
    do_req(10, 2'd0, 1, 8'h22, 1'b1); // R10: still invalid -> miss, SC fill
    do_snoop(8, 1'b0, 3, 8'h77);      // R8: SD supplies, stays SD
    do_req(2, 2'd0, 3, 8'h77, 1'b0);  // R2/R8: confirm SD
    // R11: stall while bus is held by another cache
    @(negedge clk);
    bus_busy = 1'b1; req_valid = 1'b1; req_op = 2'd1; req_idx = 2'd3; req_tag = 8'h77;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req_ready === 1'b0, 11, "ready while busy", int'(req_ready), 0);
      @(negedge clk);
      chk(resp_valid === 1'b0, 11, "response while busy", int'(resp_valid), 0);
    end
    req_valid = 1'b0; bus_busy = 1'b0;
    do_req(11, 2'd0, 3, 8'h77, 1'b0); // R11: state unchanged by stalled write (SD)
    do_req(7, 2'd2, 2, 8'h66, 1'b0);  // R7: evict D with write-back
    do_req(7, 2'd2, 2, 8'h66, 1'b0);  // R7: evict of invalid line, no write-back
    repeat (3) @(negedge clk);
    chk(q.size() == 0, 11, "responses outstanding", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule